// File: doc/BRIEF.md
# YCbCr to RGB Pixel Converter

This block converts a 4:2:2 luma/chroma pixel stream into packed RGB words for a display or frame store. Each input beat carries an 8-bit luma sample and one 8-bit chroma sample. Chroma alternates between Cb and Cr, and a blanking flag marks the inactive parts of a line. Before the colour matrix runs, the block rebuilds full 4:4:4 chroma for every pixel by reusing the most recent sample of the other component.

The matrix scales luma and chroma straight into 5-bit or 6-bit code ranges, removes the black and mid-chroma offsets, rounds, and saturates. The result can be sent out as-is (gamma-corrected codes) or passed through a linearizing curve. Two curves are available: one with an exponent of 2.2 and a short linear toe, and one with a pure 2.8 power law. The curves are computed as small tables when the design is elaborated.

A pass-through YCbCr mode sends luma and the raw chroma sample unchanged. Configuration inputs are static while pixels are in flight. The output is a registered word with valid and blank flags, three clock cycles after the input.

Top module: `ycc2rgb_conv`

## Requirements
- R1: A beat sampled with `in_valid` high appears on `out_valid` exactly three rising edges later. `out_blank` carries the beat's `in_blank` through the same delay. No output word is produced for a cycle with `in_valid` low.
- R2: After reset, and after any valid beat with `in_blank` high, the next valid non-blank beat carries Cb. Valid non-blank beats then alternate Cb, Cr. A Cb beat uses its own Cb and the last held Cr. A Cr beat uses the last held Cb and its own Cr. Both held values are 128 after reset. Blank beats and idle cycles do not change the held values.
- R3: In 5-5-5 mode, with dy = Y-16, du = Cb-128 and dv = Cr-128:
  - R = q(145dy+199dv)
  - G = q(145dy-101dv-49du)
  - B = q(145dy+251du)
  - q(s) = floor((s+512)/1024).
- R4: In 5-6-5 mode, G = q(295dy-206dv-99du). R and B are the same as in R3.
- R5: Any channel result below 0 is output as 0.
- R6: A red or blue result above 31 is output as 31. A green result above 31 (5-5-5 mode) or above 63 (5-6-5 mode) is output as that limit.
- R7: Packing in 5-5-5 mode is {1'b0, R[4:0], G[4:0], B[4:0]}. Packing in 5-6-5 mode is {R[4:0], G[5:0], B[4:0]}.
- R8: In RGB mode, a beat with `in_blank` high produces `out_data` = 0, whatever its samples are.
- R9: In YCbCr mode (`cfg_rgb`=0), `out_data` = {Y, chroma sample of that beat}. A blank beat produces 16'h1080 (Y 16, chroma 128).
- R10: With linearization on and `cfg_gam28`=0, each channel code v of full scale F (31 or 63) becomes round(F·L), where n = v/F, and:
  - L = n/4.5 when n < 0.0812;
  - otherwise L = ((n+0.099)/1.099)^2.2.
- R11: With linearization on and `cfg_gam28`=1, each code becomes round(F·(v/F)^2.8). With linearization off, the codes from R3 to R6 pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_blank | input | 1 | Beat lies in blanking |
| in_luma | input | 8 | Luma sample |
| in_chroma | input | 8 | Chroma sample, Cb and Cr alternating |
| cfg_rgb | input | 1 | 1: RGB output, 0: YCbCr pass-through |
| cfg_g6 | input | 1 | 1: 5-6-5 packing, 0: 5-5-5 packing |
| cfg_lin | input | 1 | Apply the linearizing curve |
| cfg_gam28 | input | 1 | Curve select: 0 gives 2.2, 1 gives 2.8 |
| out_valid | output | 1 | Output word present |
| out_blank | output | 1 | Output word came from a blank beat |
| out_data | output | 16 | Packed pixel word |

## Verification
Blank forcing and chroma phase handling act on the same beat. A blank beat must zero the word, or give 16'h1080, even when its samples would saturate the matrix. That same beat must also restart the Cb/Cr phase without touching the held chroma. The bench sends blank beats with extreme luma and chroma in the middle of colour runs. It then checks both the forced word and the colour of the non-blank pixels that follow, which reveal the phase and the held values the blank beat left behind. Clamping and linearization meet in the same way: saturated codes are fed through both curves so that the table end points are exercised.

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv #(
  parameter int FRAC = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_blank,
  input  logic [7:0]  in_luma,
  input  logic [7:0]  in_chroma,
  input  logic        cfg_rgb,
  input  logic        cfg_g6,
  input  logic        cfg_lin,
  input  logic        cfg_gam28,
  output logic        out_valid,
  output logic        out_blank,
  output logic [15:0] out_data
);
  localparam int AW = 22;
  localparam logic signed [AW-1:0] HALF = AW'(1 << (FRAC - 1));
  localparam logic signed [AW-1:0] K_YL = 22'sd145;
  localparam logic signed [AW-1:0] K_YH = 22'sd295;
  localparam logic signed [AW-1:0] K_RV = 22'sd199;
  localparam logic signed [AW-1:0] K_GV = 22'sd101;
  localparam logic signed [AW-1:0] K_GU = 22'sd49;
  localparam logic signed [AW-1:0] K_GV6 = 22'sd206;
  localparam logic signed [AW-1:0] K_GU6 = 22'sd99;
  localparam logic signed [AW-1:0] K_BU = 22'sd251;

  function automatic int gam_code(int v, int fs, bit g28);
    real n, l;
    n = real'(v) / real'(fs);
    if (g28) l = n ** 2.8;
    else if (n < 0.0812) l = n / 4.5;
    else l = ((n + 0.099) / 1.099) ** 2.2;
    return $rtoi(l * real'(fs) + 0.5);
  endfunction

  function automatic logic [5:0] sat(logic signed [AW-1:0] acc, logic [5:0] lim);
    logic signed [AW-1:0] q;
    q = (acc + HALF) >>> FRAC;
    if (q < 0) return 6'd0;
    if (q > $signed({16'd0, lim})) return lim;
    return q[5:0];
  endfunction

  // chroma phase and held samples
  logic       ph;
  logic [7:0] hold_cb, hold_cr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= 1'b0; hold_cb <= 8'd128; hold_cr <= 8'd128;
    end else if (in_valid) begin
      if (in_blank) ph <= 1'b0;
      else begin
        ph <= ~ph;
        if (!ph) hold_cb <= in_chroma;
        else     hold_cr <= in_chroma;
      end
    end

  // stage 1: 4:4:4 sample
  logic       s1_valid, s1_blank;
  logic [7:0] s1_y, s1_cb, s1_cr, s1_c;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_valid <= 1'b0; s1_blank <= 1'b0;
      s1_y <= '0; s1_cb <= 8'd128; s1_cr <= 8'd128; s1_c <= 8'd128;
    end else begin
      s1_valid <= in_valid;
      s1_blank <= in_blank;
      s1_y     <= in_luma;
      s1_c     <= in_chroma;
      s1_cb    <= ph ? hold_cb : in_chroma;
      s1_cr    <= ph ? in_chroma : hold_cr;
    end

  // stage 2: matrix, round, clamp
  logic signed [AW-1:0] dy, du, dv, acc_r, acc_g, acc_b;
  assign dy = $signed({14'd0, s1_y}) - 22'sd16;
  assign du = $signed({14'd0, s1_cb}) - 22'sd128;
  assign dv = $signed({14'd0, s1_cr}) - 22'sd128;
  assign acc_r = K_YL * dy + K_RV * dv;
  assign acc_b = K_YL * dy + K_BU * du;
  assign acc_g = cfg_g6 ? (K_YH * dy - K_GV6 * dv - K_GU6 * du)
                        : (K_YL * dy - K_GV * dv - K_GU * du);

  logic       s2_valid, s2_blank;
  logic [4:0] s2_r, s2_b;
  logic [5:0] s2_g, sat_r, sat_b;
  logic [7:0] s2_y, s2_c;
  assign sat_r = sat(acc_r, 6'd31);
  assign sat_b = sat(acc_b, 6'd31);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_valid <= 1'b0; s2_blank <= 1'b0;
      s2_r <= '0; s2_g <= '0; s2_b <= '0; s2_y <= '0; s2_c <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_blank <= s1_blank;
      s2_r     <= sat_r[4:0];
      s2_b     <= sat_b[4:0];
      s2_g     <= sat(acc_g, cfg_g6 ? 6'd63 : 6'd31);
      s2_y     <= s1_y;
      s2_c     <= s1_c;
    end

  // stage 3: linearizing tables and packing
  logic [4:0] t5a [32];
  logic [4:0] t5b [32];
  logic [5:0] t6a [64];
  logic [5:0] t6b [64];
  for (genvar i = 0; i < 32; i++) begin : g_t5
    assign t5a[i] = 5'(gam_code(i, 31, 1'b0));
    assign t5b[i] = 5'(gam_code(i, 31, 1'b1));
  end
  for (genvar i = 0; i < 64; i++) begin : g_t6
    assign t6a[i] = 6'(gam_code(i, 63, 1'b0));
    assign t6b[i] = 6'(gam_code(i, 63, 1'b1));
  end

  logic [4:0]  rr, bb, g5;
  logic [5:0]  gg;
  logic [15:0] nxt;
  assign rr = !cfg_lin ? s2_r : (cfg_gam28 ? t5b[s2_r] : t5a[s2_r]);
  assign bb = !cfg_lin ? s2_b : (cfg_gam28 ? t5b[s2_b] : t5a[s2_b]);
  assign gg = !cfg_lin ? s2_g : (cfg_gam28 ? t6b[s2_g] : t6a[s2_g]);
  assign g5 = !cfg_lin ? s2_g[4:0] : (cfg_gam28 ? t5b[s2_g[4:0]] : t5a[s2_g[4:0]]);

  always_comb begin
    if (!cfg_rgb)      nxt = s2_blank ? 16'h1080 : {s2_y, s2_c};
    else if (s2_blank) nxt = 16'h0000;
    else if (cfg_g6)   nxt = {rr, gg, bb};
    else               nxt = {1'b0, rr, g5, bb};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_blank <= 1'b0; out_data <= '0;
    end else begin
      out_valid <= s2_valid;
      out_blank <= s2_blank;
      out_data  <= nxt;
    end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid); // R1
  AST_BLANK_RGB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_blank && cfg_rgb) |=> (out_data == 16'h0000)); // R8
  AST_BLANK_YCC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_blank && !cfg_rgb) |=> (out_data == 16'h1080)); // R9
  AST_BLACK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_blank && s1_y <= 8'd16 && s1_cb == 8'd128 && s1_cr == 8'd128)
      |=> (s2_r == 5'd0 && s2_g == 6'd0 && s2_b == 5'd0)); // R5
  AST_GREEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !cfg_g6) |=> (s2_g <= 6'd31)); // R6
endmodule

// File: tb/sim_ycc2rgb_conv.sv
module sim_ycc2rgb_conv;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_blank = 1'b0;
  logic [7:0] in_luma = '0, in_chroma = '0;
  logic cfg_rgb = 1'b1, cfg_g6 = 1'b0, cfg_lin = 1'b0, cfg_gam28 = 1'b0;
  logic out_valid, out_blank;
  logic [15:0] out_data;

  always #2 clk = ~clk;

  ycc2rgb_conv u0 (.clk, .rst_n, .in_valid, .in_blank, .in_luma, .in_chroma,
                   .cfg_rgb, .cfg_g6, .cfg_lin, .cfg_gam28,
                   .out_valid, .out_blank, .out_data);

  int checks = 0, fails = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  int m_ph = 0, m_cb = 128, m_cr = 128;

  function automatic int q10(int s);
    return (s + 512) >>> 10;
  endfunction
  function automatic int clampv(int v, int lim);
    return v < 0 ? 0 : (v > lim ? lim : v);
  endfunction
  function automatic int curve(int v, int fs, bit g28);
    real n, l;
    n = real'(v) / real'(fs);
    if (g28) l = n ** 2.8;
    else if (n < 0.0812) l = n / 4.5;
    else l = ((n + 0.099) / 1.099) ** 2.2;
    return $rtoi(l * real'(fs) + 0.5);
  endfunction

  task automatic report(bit ok, string tag, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(int y, int c, bit blk, string tag);
    int cb, cr, dy, du, dv, r, g, b, gl;
    logic [15:0] w;
    cb = m_cb; cr = m_cr;
    if (blk) m_ph = 0;
    else if (m_ph == 0) begin cb = c; m_cb = c; m_ph = 1; end
    else begin cr = c; m_cr = c; m_ph = 0; end
    dy = y - 16; du = cb - 128; dv = cr - 128;
    gl = cfg_g6 ? 63 : 31;
    r = clampv(q10(145*dy + 199*dv), 31);
    b = clampv(q10(145*dy + 251*du), 31);
    g = cfg_g6 ? clampv(q10(295*dy - 206*dv - 99*du), 63)
               : clampv(q10(145*dy - 101*dv - 49*du), 31);
    if (cfg_lin) begin
      r = curve(r, 31, cfg_gam28); b = curve(b, 31, cfg_gam28); g = curve(g, gl, cfg_gam28);
    end
    if (!cfg_rgb) w = blk ? 16'h1080 : {8'(y), 8'(c)};
    else if (blk) w = 16'h0000;
    else if (cfg_g6) w = {5'(r), 6'(g), 5'(b)};
    else w = {1'b0, 5'(r), 5'(g), 5'(b)};
    exp_q.push_back({blk, w});
    tag_q.push_back(tag);
    in_valid = 1'b1; in_blank = blk; in_luma = 8'(y); in_chroma = 8'(c);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) report(1'b0, "R1 extra word", {out_blank, out_data}, '0);
      else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report({out_blank, out_data} === e, t, {out_blank, out_data}, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    report(out_valid === 1'b0, "R1 reset valid", {16'd0, out_valid}, '0);
    report(out_data === 16'h0, "R1 reset data", {1'b0, out_data}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // latency R1
    send(235, 128, 0, "R1 latency word");
    @(negedge clk);
    report(out_valid === 1'b0, "R1 early", {16'd0, out_valid}, '0);
    @(negedge clk);
    report(out_valid === 1'b1, "R1 on time", {16'd0, out_valid}, 17'd1);
    idle(2);
    send(0, 0, 1, "R2 phase restart");
    idle(5);

    // 5-5-5 matrix R3 R5 R6 R7
    send(16, 128, 0, "R3 black"); send(235, 128, 0, "R3 white");
    send(81, 90, 0, "R3 red Cb"); send(81, 240, 0, "R3 red Cr");
    send(145, 54, 0, "R7 green"); send(145, 34, 0, "R7 green Cr");
    send(5, 128, 0, "R5 below black"); send(0, 0, 0, "R5 deep neg");
    send(255, 255, 0, "R6 over Cb"); send(255, 255, 0, "R6 over Cr");
    send(255, 0, 0, "R6 mix Cb"); send(40, 0, 0, "R5 mix Cr");
    // blank with extreme samples, then phase restart R2 R8
    send(255, 255, 1, "R8 blank sat");
    send(120, 200, 0, "R2 Cb after blank"); send(120, 60, 0, "R2 Cr after");
    send(120, 10, 0, "R2 Cb again");
    idle(3);
    send(200, 30, 0, "R2 idle keeps phase Cr");
    send(90, 250, 1, "R8 blank two");
    send(90, 180, 0, "R2 held Cr kept");
    idle(6);

    // 5-6-5 R4 R7
    cfg_g6 = 1'b1; idle(2);
    for (int i = 0; i < 24; i++) send(16 + i*10, (i*37) % 256, 0, "R4 ramp");
    send(255, 0, 0, "R6 g6 top"); send(255, 0, 0, "R6 g6 top Cr");
    send(10, 255, 0, "R5 g6 low"); send(10, 255, 0, "R5 g6 low Cr");
    send(3, 3, 1, "R8 blank g6");
    idle(6);

    // linearization R10 R11
    cfg_lin = 1'b1;
    for (int m = 0; m < 4; m++) begin
      cfg_g6 = m[0]; cfg_gam28 = m[1]; idle(4);
      for (int i = 0; i < 40; i++)
        send(16 + (i*11) % 240, (i*53 + 7) % 256, 0, m[1] ? "R11 curve 2.8" : "R10 curve 2.2");
      send(255, 255, 0, m[1] ? "R11 top" : "R10 top");
      send(255, 255, 0, m[1] ? "R11 top Cr" : "R10 top Cr");
      send(200, 0, 1, "R8 blank lin");
      idle(6);
    end
    cfg_lin = 1'b0; cfg_gam28 = 1'b0; cfg_g6 = 1'b0; idle(2);
    send(100, 100, 0, "R11 bypass"); idle(6);

    // YCbCr mode R9
    cfg_rgb = 1'b0; idle(2);
    send(50, 77, 0, "R9 pass"); send(200, 3, 0, "R9 pass Cr");
    send(255, 255, 1, "R9 blank level"); send(0, 0, 1, "R9 blank low");
    send(17, 240, 0, "R9 after blank");
    idle(8);

    report(exp_q.size() == 0, "R1 drained", 17'(exp_q.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule